// File: doc/BRIEF.md
# Serial PHY Management Frame Engine

This block runs single management transactions on the two-wire PHY management interface, MDC and MDIO. Software writes one 32-bit command word. The write launches a complete clause-22 frame: a 32-bit all-ones preamble, followed by the 32 bits of the word shifted out most significant bit first. The word itself gives the start code, the opcode, the PHY address, the register address, the turnaround bits and the data field. While the frame is on the wire, the idle output is low. The caller polls idle until it returns high.

In a read frame (opcode `10`), the engine stops driving MDIO after the 14 header bits. It then samples the 16 bits that the PHY returns and writes them, in place, into the data field of the command word. The caller reads the result back on `rd_data`. MDC is generated from the system clock. The division ratio is fixed at elaboration from the `SYS_CLK_HZ` parameter and is one of four power-of-two values. The enable input `mgmt_en` gates the start of a transaction.

Top module: `mdio_mgmt_engine`

## Requirements
- R1: After reset, `idle` is 1, `mdc` is 0, `mdio_oe` is 0 and `rd_data` is 0.
- R2: A write strobe with `mgmt_en` high while `idle` is high does two things. It loads `wr_data` into the command word, which `rd_data` shows. It also drives `idle` low in the following cycle. `idle` stays low for exactly 64 MDC periods of RATIO system clocks each.
- R3: A write strobe while `mgmt_en` is low has no effect: `idle` stays high and `rd_data` is unchanged.
- R4: A write strobe while a frame is in progress is ignored: the frame on the wire and `rd_data` both continue from the original word.
- R5: Each frame puts 64 bits on MDIO. The first 32 bits are ones. The next 32 are command word bits 31 down to 0, in that order. MDIO changes only when MDC falls. Each bit period starts with MDC low for half the period, and MDC is high for the second half.
- R6: When the opcode field (bits 29:28) is anything other than `10`, `mdio_oe` is high for all 64 bits.
- R7: When the opcode field is `10`, `mdio_oe` is high for the preamble and for word bits 31..18. It is low for the two turnaround bits and the 16 data bits. The value of `mdio_in` at each of the last 16 MDC rising edges replaces word bits 15..0, most significant bit first. Word bits 31..16 are unchanged.
- R8: RATIO is 8 when `SYS_CLK_HZ` is at most 20 MHz, 16 when it is at most 40 MHz, 32 when it is at most 80 MHz, and 64 otherwise. MDC is high for RATIO/2 clocks of each period.
- R9: While `idle` is high, `mdc` is 0 and `mdio_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mgmt_en | input | 1 | Management port enable; gates the start of a transaction |
| wr_en | input | 1 | One-cycle write strobe for the command word |
| wr_data | input | 32 | Command word to launch |
| rd_data | output | 32 | Current command word, including any captured read data |
| idle | output | 1 | High when no frame is in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output level |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input level |

## Verification
The assertions assume three things about the inputs. Commands come only as single-cycle write strobes. `mdio_i` is changed only while MDC is low, so the value sampled at a rising edge is stable. `mgmt_en` is changed only while the engine is idle. The stimulus meets all three. The bench drives its PHY response only on MDC falling edges, and it toggles `mgmt_en` only between frames. Writes during a frame are issued deliberately, to show that they are dropped.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int PRE_LEN       = 32;
    localparam int BODY_LEN      = 32;
    localparam int FRAME_LEN     = PRE_LEN + BODY_LEN;
    localparam int IDX_W         = $clog2(FRAME_LEN);
    localparam int POS_W         = $clog2(BODY_LEN);
    localparam int HDR_LEN       = 14;
    localparam int TA_LEN        = 2;
    localparam int RD_DATA_START = HDR_LEN + TA_LEN;
    localparam int DATA_LEN      = 16;

    typedef enum logic [1:0] {
        OP_RSVD0 = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_RSVD3 = 2'b11
    } mdio_op_e;

    typedef struct packed {
        logic [1:0]          sof;
        mdio_op_e            op;
        logic [4:0]          phy_addr;
        logic [4:0]          reg_addr;
        logic [1:0]          turn;
        logic [DATA_LEN-1:0] data;
    } mgmt_word_t;

    typedef struct packed {
        logic             drive;
        logic             level;
        logic             capture;
        logic [POS_W-1:0] pos;
    } pin_ctl_t;

    function automatic int mdc_ratio(input longint unsigned hz);
        if (hz <= 64'd20_000_000)      return 8;
        else if (hz <= 64'd40_000_000) return 16;
        else if (hz <= 64'd80_000_000) return 32;
        else                           return 64;
    endfunction

endpackage

// File: rtl/mdio_bit_timer.sv
module mdio_bit_timer #(
    parameter int RATIO = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic mdc,
    output logic sample_tick,
    output logic bit_end
);
    localparam int CW   = $clog2(RATIO);
    localparam int HALF = RATIO / 2;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] hi_run_q;

    always_ff @(posedge clk) begin
        if (rst || !run) cnt_q <= '0;
        else if (bit_end) cnt_q <= '0;
        else              cnt_q <= cnt_q + 1'b1;
    end

    assign mdc         = run & cnt_q[CW-1];
    assign sample_tick = run && (cnt_q == CW'(HALF - 1));
    assign bit_end     = run && (cnt_q == CW'(RATIO - 1));

    // Counts the consecutive cycles for which mdc has already been high.
    always_ff @(posedge clk) begin
        if (rst || !mdc) hi_run_q <= '0;
        else             hi_run_q <= hi_run_q + 1'b1;
    end

    p_mdc_high_width_r8: assert property (@(posedge clk) disable iff (rst)
        mdc |-> (hi_run_q < CW'(HALF)));

    p_bit_end_high_r5: assert property (@(posedge clk) disable iff (rst)
        bit_end |-> mdc);

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             bit_end,
    output logic             busy,
    output logic [IDX_W-1:0] bit_idx
);
    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            bit_idx <= '0;
        end else if (start) begin
            busy    <= 1'b1;
            bit_idx <= '0;
        end else if (busy && bit_end) begin
            if (bit_idx == IDX_W'(FRAME_LEN - 1)) begin
                busy    <= 1'b0;
                bit_idx <= '0;
            end else begin
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end

    p_idx_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (busy && !bit_end && !start) |=> $stable(bit_idx));

endmodule

// File: rtl/mdio_pin_ctl.sv
module mdio_pin_ctl
    import mdio_pkg::*;
(
    input  logic             busy,
    input  logic [IDX_W-1:0] bit_idx,
    input  mgmt_word_t       word,
    output pin_ctl_t         ctl
);
    logic [IDX_W-1:0] body_full;
    logic [POS_W-1:0] j;
    logic             in_body;
    logic             is_read;
    logic             released;
    logic [BODY_LEN-1:0] bits;

    always_comb begin
        bits      = word;
        in_body   = bit_idx >= IDX_W'(PRE_LEN);
        body_full = bit_idx - IDX_W'(PRE_LEN);
        j         = body_full[POS_W-1:0];
        is_read   = (word.op == OP_READ);
        released  = is_read && in_body && (j >= POS_W'(HDR_LEN));

        ctl.pos     = POS_W'(BODY_LEN - 1) - j;
        ctl.drive   = busy && !released;
        ctl.level   = (busy && in_body && !released) ? bits[ctl.pos] : 1'b1;
        ctl.capture = busy && is_read && in_body && (j >= POS_W'(RD_DATA_START));
    end

endmodule

// File: rtl/mdio_mgmt_engine.sv
module mdio_mgmt_engine
    import mdio_pkg::*;
#(
    parameter longint unsigned SYS_CLK_HZ = 100_000_000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        mgmt_en,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        idle,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    localparam int RATIO = mdc_ratio(SYS_CLK_HZ);

    mgmt_word_t       word_q;
    logic             busy;
    logic [IDX_W-1:0] bit_idx;
    logic             sample_tick;
    logic             bit_end;
    logic             accept;
    pin_ctl_t         ctl;

    assign accept = wr_en && mgmt_en && !busy;

    mdio_bit_timer #(.RATIO(RATIO)) u_timer (
        .clk         (clk),
        .rst         (rst),
        .run         (busy),
        .mdc         (mdc),
        .sample_tick (sample_tick),
        .bit_end     (bit_end)
    );

    mdio_frame_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (accept),
        .bit_end (bit_end),
        .busy    (busy),
        .bit_idx (bit_idx)
    );

    mdio_pin_ctl u_pins (
        .busy    (busy),
        .bit_idx (bit_idx),
        .word    (word_q),
        .ctl     (ctl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (accept) begin
            word_q <= mgmt_word_t'(wr_data);
        end else if (ctl.capture && sample_tick) begin
            word_q.data[ctl.pos[$clog2(DATA_LEN)-1:0]] <= mdio_i;
        end
    end

    assign rd_data = word_q;
    assign idle    = !busy;
    assign mdio_o  = ctl.level;
    assign mdio_oe = ctl.drive;

    p_idle_drop_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && mgmt_en && idle) |=> !idle);

    p_ignore_disabled_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !mgmt_en && idle) |=> (idle && $stable(rd_data)));

    p_ignore_busy_r4: assert property (@(posedge clk) disable iff (rst)
        (!idle && word_q.op != OP_READ) |=> $stable(rd_data));

    p_edge_align_r5: assert property (@(posedge clk) disable iff (rst)
        (!idle && $past(!idle) && !$stable(mdio_o)) |-> $fell(mdc));

    p_release_r7: assert property (@(posedge clk) disable iff (rst)
        (!idle && word_q.op == OP_READ && bit_idx >= IDX_W'(PRE_LEN + HDR_LEN)) |-> !mdio_oe);

    p_idle_pins_r9: assert property (@(posedge clk) disable iff (rst)
        idle |-> (!mdc && !mdio_oe));

endmodule

// File: tb/mdio_mgmt_engine_test.sv
module mdio_mgmt_engine_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mgmt_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        idle, mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    logic        wr20 = 1'b0;
    logic [31:0] rd20;
    logic        idle20, mdc20, mdo20, mdoe20;

    int errs = 0;
    int checks = 0;
    int cyc = 0;

    logic [15:0] phy_resp = '0;
    int          rise_cnt = 0;
    logic [63:0] cap_o = '0;
    logic [63:0] cap_oe = '0;

    always #2 clk = ~clk;

    mdio_mgmt_engine #(.SYS_CLK_HZ(250_000_000)) uut (
        .clk(clk), .rst(rst), .mgmt_en(mgmt_en), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .idle(idle), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    mdio_mgmt_engine #(.SYS_CLK_HZ(20_000_000)) uut20 (
        .clk(clk), .rst(rst), .mgmt_en(1'b1), .wr_en(wr20), .wr_data(32'h5192A5C3),
        .rd_data(rd20), .idle(idle20), .mdc(mdc20), .mdio_o(mdo20),
        .mdio_oe(mdoe20), .mdio_i(1'b1)
    );

    // Bench PHY: record the line at each MDC rise, drive response data on MDC falls.
    always @(posedge mdc) begin
        if (rise_cnt < 64) begin
            cap_o[63 - rise_cnt]  = mdio_o;
            cap_oe[63 - rise_cnt] = mdio_oe;
        end
        rise_cnt = rise_cnt + 1;
    end

    always @(negedge mdc) begin
        if (rise_cnt >= 48 && rise_cnt < 64) mdio_i = phy_resp[63 - rise_cnt];
        else                                 mdio_i = 1'b1;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_frame(input logic [31:0] word, input logic [15:0] resp,
                             input bit intrude, input logic [31:0] alt);
        logic [63:0] exp_o, exp_oe, mask;
        logic [31:0] exp_rd;
        bit          rd;
        int          cycles;
        phy_resp = resp;
        rise_cnt = 0;
        mdio_i   = 1'b1;
        rd       = (word[29:28] == 2'b10);
        exp_rd   = rd ? {word[31:16], resp} : word;
        for (int r = 0; r < 64; r++) begin
            if (r < 32) begin
                exp_o[63 - r] = 1'b1; exp_oe[63 - r] = 1'b1;
            end else begin
                exp_oe[63 - r] = !(rd && (r - 32) >= 14);
                exp_o[63 - r]  = exp_oe[63 - r] ? word[63 - r] : 1'b0;
            end
        end
        mask = exp_oe;
        @(negedge clk);
        chk(idle == 1'b1 && mdc == 1'b0 && mdio_oe == 1'b0, "R9 idle pins", {idle, mdc, mdio_oe}, 3'b100);
        wr_data = word; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        chk(idle == 1'b0, "R2 idle low after write", idle, 0);
        cycles = 1;
        while (!idle && cycles < 20000) begin
            wr_en = (intrude && cycles == 100);
            if (wr_en) wr_data = alt;
            @(negedge clk);
            cycles++;
        end
        wr_en = 1'b0;
        chk(cycles - 1 == 64 * 64, "R2 frame length", cycles - 1, 64 * 64);
        chk(rise_cnt == 64, "R5 MDC rising edges", rise_cnt, 64);
        chk(cap_oe == exp_oe, rd ? "R7 output enable" : "R6 output enable", cap_oe, exp_oe);
        chk((cap_o & mask) == (exp_o & mask), "R5 serial bits", cap_o & mask, exp_o & mask);
        chk(rd_data == exp_rd, intrude ? "R4 word kept" : (rd ? "R7 read data" : "R2 word loaded"),
            rd_data, exp_rd);
    endtask

    // {command word, PHY response}
    localparam logic [47:0] VECS [6] = '{
        {32'h5192A5C3, 16'h0000},
        {32'h6F860000, 16'hBEEF},
        {32'h607E1234, 16'h0001},
        {32'h5556FFFF, 16'h7777},
        {32'h51920000, 16'hFFFF},
        {32'h6F86ABCD, 16'h8000}
    };

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        int busy20;
        int hi20;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(idle == 1'b1, "R1 idle", idle, 1);
        chk(mdc == 1'b0, "R1 mdc", mdc, 0);
        chk(mdio_oe == 1'b0, "R1 oe", mdio_oe, 0);
        chk(rd_data == 32'h0, "R1 rd_data", rd_data, 0);

        // R3: write while disabled
        wr_data = 32'h5192AAAA; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        chk(idle == 1'b1, "R3 idle stays high", idle, 1);
        repeat (10) @(negedge clk);
        chk(rd_data == 32'h0 && mdc == 1'b0, "R3 word unchanged", rd_data, 0);

        mgmt_en = 1'b1;
        for (int v = 0; v < 6; v++) begin
            run_frame(VECS[v][47:16], VECS[v][15:0], 1'b0, 32'h0);
        end

        // R4: write attempt in the middle of a write frame
        run_frame(32'h5556C3C3, 16'h0, 1'b1, 32'h6F861111);

        // R3 again after activity: disabled write leaves result intact
        mgmt_en = 1'b0;
        @(negedge clk);
        wr_data = 32'h607E0000; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (5) @(negedge clk);
        chk(idle == 1'b1 && rd_data == 32'h5556C3C3, "R3 disabled after frames", rd_data, 32'h5556C3C3);

        // R8: slow-clock instance uses ratio 8
        @(negedge clk);
        wr20 = 1'b1;
        @(negedge clk);
        wr20 = 1'b0;
        busy20 = 0;
        hi20 = 0;
        while (!idle20 && busy20 < 5000) begin
            busy20++;
            if (mdc20) hi20++;
            @(negedge clk);
        end
        chk(busy20 == 64 * 8, "R8 frame length at ratio 8", busy20, 64 * 8);
        chk(hi20 == 64 * 4, "R8 MDC high time at ratio 8", hi20, 64 * 4);
        chk(rd20 == 32'h5192A5C3, "R8 word loaded", rd20, 32'h5192A5C3);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule